// File: doc/BRIEF.md
# Packed Shift, Pack and Unpack Unit

This unit is one execution lane of a packed-integer datapath. Each accepted operation takes two 64-bit operands. It produces a 64-bit result that is registered and appears one clock later. Three kinds of work are available:

- Shifts, applied independently inside 16-bit or 32-bit elements, or to the whole 64-bit word. The whole-word shift moves packed data into new positions, which is used to realign data that does not start on a 64-bit boundary.
- Narrowing with saturation (pack), where the elements of both operands are clipped into half-width elements.
- Widening by interleaving (unpack), where elements from the low or high halves of both operands are merged.

The shift count comes either from an 8-bit immediate field or from the full 64-bit second operand. The caller selects which one for each operation. Counts that reach or pass the element width are handled explicitly, so they never wrap.

There is no handshake. A valid bit marks each issued operation, and the same bit comes back with the result.

Top module: `psp_unit`

## Requirements
- R1: When `in_valid` is high at a rising edge, the result of that operation appears on `result_o` and `out_valid_o` goes high after exactly that one edge. `out_valid_o` is low in any cycle that follows an edge with `in_valid` low. Reset drives `result_o` and `out_valid_o` to zero.
- R2: Left shift (op 0) shifts each element left and fills with zeros. `lane_i` selects the element size: 1 for 16 bits, 2 for 32 bits, 3 for the whole 64-bit word.
- R3: Logical right shift (op 1) shifts each selected element right and fills with zeros.
- R4: Arithmetic right shift (op 2) shifts each selected element right and fills with copies of that element's top bit.
- R5: With `use_imm_i` high, the count is `imm_i`, zero-extended. With `use_imm_i` low, the count is the whole 64-bit value of `b_i`.
- R6: A count equal to or greater than the element width gives an all-zero element for ops 0 and 1. For op 2 it gives an element filled with its sign bit.
- R7: Signed pack (op 3) treats the elements as signed and clamps them into the signed range of half their width. With `lane_i`=1 it narrows 16-bit elements to 8 bits. With `lane_i`=2 it narrows 32-bit elements to 16 bits. The narrowed elements of `a_i` fill the low 32 bits of the result in element order, and those of `b_i` fill the high 32 bits.
- R8: Unsigned pack (op 4, `lane_i`=1 only) treats the 16-bit elements as signed. It maps negative values to 0 and values above 255 to 255, with the same half placement as R7.
- R9: Unpack low (op 5) interleaves the elements of the low 32 bits of `a_i` and `b_i`. Unpack high (op 6) does the same with the high 32 bits. The element size is 8, 16 or 32 bits for `lane_i` 0, 1 or 2. In each pair, the element from `a_i` takes the lower position.
- R10: Unsupported combinations give a zero result. These are: a shift with `lane_i`=0, signed pack with `lane_i` 0 or 3, unsigned pack with `lane_i` other than 1, unpack with `lane_i`=3, and op 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation issued this cycle |
| op_i | input | 3 | Operation code (see R2–R10) |
| lane_i | input | 2 | Element size select |
| use_imm_i | input | 1 | Take the shift count from `imm_i` instead of `b_i` |
| imm_i | input | 8 | Immediate shift count |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand / register shift count |
| out_valid_o | output | 1 | Result valid |
| result_o | output | 64 | Registered result |

## Verification
The hardest case to reach from the ports is a register-supplied count whose low bits look small while its upper bits are set. If the design compared only part of the count, such a value would pass for a short shift. The stimulus drives `b_i` with values such as bit 32 set over a low count of 3, and values exactly equal to each element width. It does this for all three shift kinds and all three element sizes. Saturation edges are reached by placing the exact boundary values (127, 128, −128, −129, 255, 256, 32767, −32769) in the pack operands. Long runs with random operands then go back to back, so each result must line up with its own issue cycle.

// File: rtl/psp_pkg.sv
package psp_pkg;
    localparam int DW = 64;

    typedef enum logic [2:0] {
        OP_SHL  = 3'd0,
        OP_SHRL = 3'd1,
        OP_SHRA = 3'd2,
        OP_PKSS = 3'd3,
        OP_PKUS = 3'd4,
        OP_UNLO = 3'd5,
        OP_UNHI = 3'd6,
        OP_RSVD = 3'd7
    } psp_op_e;

    typedef enum logic [1:0] {
        LN_B = 2'd0,
        LN_W = 2'd1,
        LN_D = 2'd2,
        LN_Q = 2'd3
    } psp_lane_e;

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] res;
    } psp_state_t;
endpackage

// File: rtl/psp_shifter.sv
module psp_shifter
    import psp_pkg::*;
#(
    parameter int W_DW = DW
) (
    input  logic [W_DW-1:0] a_i,
    input  logic [W_DW-1:0] cnt_i,
    input  psp_op_e         mode_i,
    input  psp_lane_e       lane_i,
    output logic [W_DW-1:0] res_o
);
    localparam int NG = 3;  // 16, 32, full width

    logic [W_DW-1:0] gres [NG];

    for (genvar g = 0; g < NG; g++) begin : g_size
        localparam int W  = (g == NG-1) ? W_DW : (16 << g);
        localparam int SW = $clog2(W);
        localparam int NL = W_DW / W;

        logic            big;
        logic [SW-1:0]   amt;
        logic [SW-1:0]   samt;
        logic [W_DW-1:0] lres;

        assign big  = (cnt_i >= W_DW'(W));
        assign amt  = cnt_i[SW-1:0];
        assign samt = big ? SW'(W-1) : amt;

        for (genvar l = 0; l < NL; l++) begin : g_lane
            logic [W-1:0] v;
            logic [W-1:0] shl_v;
            logic [W-1:0] shr_v;
            logic [W-1:0] sar_v;
            assign v     = a_i[l*W +: W];
            assign shl_v = big ? '0 : (v << amt);
            assign shr_v = big ? '0 : (v >> amt);
            assign sar_v = W'($signed(v) >>> samt);
            assign lres[l*W +: W] = (mode_i == OP_SHL)  ? shl_v :
                                    (mode_i == OP_SHRL) ? shr_v : sar_v;
        end

        assign gres[g] = lres;
    end

    always_comb begin
        unique case (lane_i)
            LN_W:    res_o = gres[0];
            LN_D:    res_o = gres[1];
            LN_Q:    res_o = gres[2];
            default: res_o = '0;
        endcase
    end
endmodule

// File: rtl/psp_packer.sv
module psp_packer
    import psp_pkg::*;
#(
    parameter int P_DW = DW
) (
    input  logic [P_DW-1:0] a_i,
    input  logic [P_DW-1:0] b_i,
    input  logic            uns_i,
    input  psp_lane_e       lane_i,
    output logic [P_DW-1:0] res_o
);
    localparam int HALF = P_DW / 2;
    localparam int NW   = P_DW / 16;
    localparam int ND   = P_DW / 32;

    logic [P_DW-1:0] ss16, us16, ss32;

    function automatic logic [7:0] sat_s8(input logic [15:0] x);
        if ($signed(x) > 16'sd127)       return 8'h7f;
        else if ($signed(x) < -16'sd128) return 8'h80;
        else                             return x[7:0];
    endfunction

    function automatic logic [7:0] sat_u8(input logic [15:0] x);
        if (x[15])                  return 8'h00;
        else if (x > 16'd255)       return 8'hff;
        else                        return x[7:0];
    endfunction

    function automatic logic [15:0] sat_s16(input logic [31:0] x);
        if ($signed(x) > 32'sd32767)       return 16'h7fff;
        else if ($signed(x) < -32'sd32768) return 16'h8000;
        else                               return x[15:0];
    endfunction

    for (genvar i = 0; i < NW; i++) begin : g_w
        assign ss16[i*8 +: 8]        = sat_s8(a_i[i*16 +: 16]);
        assign ss16[HALF+i*8 +: 8]   = sat_s8(b_i[i*16 +: 16]);
        assign us16[i*8 +: 8]        = sat_u8(a_i[i*16 +: 16]);
        assign us16[HALF+i*8 +: 8]   = sat_u8(b_i[i*16 +: 16]);
    end

    for (genvar i = 0; i < ND; i++) begin : g_d
        assign ss32[i*16 +: 16]      = sat_s16(a_i[i*32 +: 32]);
        assign ss32[HALF+i*16 +: 16] = sat_s16(b_i[i*32 +: 32]);
    end

    always_comb begin
        res_o = '0;
        if (lane_i == LN_W)                res_o = uns_i ? us16 : ss16;
        else if (lane_i == LN_D && !uns_i) res_o = ss32;
    end
endmodule

// File: rtl/psp_unpacker.sv
module psp_unpacker
    import psp_pkg::*;
#(
    parameter int U_DW = DW
) (
    input  logic [U_DW-1:0] a_i,
    input  logic [U_DW-1:0] b_i,
    input  logic            hi_i,
    input  psp_lane_e       lane_i,
    output logic [U_DW-1:0] res_o
);
    localparam int HALF = U_DW / 2;
    localparam int NG   = 3;  // 8, 16, 32 bit elements

    logic [HALF-1:0] ha, hb;
    logic [U_DW-1:0] gres [NG];

    assign ha = hi_i ? a_i[U_DW-1:HALF] : a_i[HALF-1:0];
    assign hb = hi_i ? b_i[U_DW-1:HALF] : b_i[HALF-1:0];

    for (genvar g = 0; g < NG; g++) begin : g_size
        localparam int W = 8 << g;
        localparam int N = HALF / W;
        logic [U_DW-1:0] lres;
        for (genvar i = 0; i < N; i++) begin : g_pair
            assign lres[(2*i)*W   +: W] = ha[i*W +: W];
            assign lres[(2*i+1)*W +: W] = hb[i*W +: W];
        end
        assign gres[g] = lres;
    end

    always_comb begin
        unique case (lane_i)
            LN_B:    res_o = gres[0];
            LN_W:    res_o = gres[1];
            LN_D:    res_o = gres[2];
            default: res_o = '0;
        endcase
    end
endmodule

// File: rtl/psp_unit.sv
module psp_unit
    import psp_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [2:0]    op_i,
    input  logic [1:0]    lane_i,
    input  logic          use_imm_i,
    input  logic [7:0]    imm_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    output logic          out_valid_o,
    output logic [DW-1:0] result_o
);
    psp_op_e    op;
    psp_lane_e  lane;
    logic [DW-1:0] cnt;
    logic [DW-1:0] sh_res, pk_res, up_res;
    psp_state_t st_d, st_q;

    assign op   = psp_op_e'(op_i);
    assign lane = psp_lane_e'(lane_i);
    assign cnt  = use_imm_i ? DW'(imm_i) : b_i;

    psp_shifter #(.W_DW(DW)) u_shift (
        .a_i(a_i), .cnt_i(cnt), .mode_i(op), .lane_i(lane), .res_o(sh_res)
    );

    psp_packer #(.P_DW(DW)) u_pack (
        .a_i(a_i), .b_i(b_i), .uns_i(op == OP_PKUS), .lane_i(lane), .res_o(pk_res)
    );

    psp_unpacker #(.U_DW(DW)) u_unpack (
        .a_i(a_i), .b_i(b_i), .hi_i(op == OP_UNHI), .lane_i(lane), .res_o(up_res)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            unique case (op)
                OP_SHL, OP_SHRL, OP_SHRA: st_d.res = sh_res;
                OP_PKSS, OP_PKUS:         st_d.res = pk_res;
                OP_UNLO, OP_UNHI:         st_d.res = up_res;
                default:                  st_d.res = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid_o = st_q.vld;
    assign result_o    = st_q.res;

    // R1
    issue_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid_o);
    // R1
    idle_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid_o);
    // R6
    over_logical_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_i == 3'd0 || op_i == 3'd1) && use_imm_i && imm_i >= 8'd64)
        |=> (result_o == '0));
    // R6
    over_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_i == 3'd2 && lane_i == 2'd3 && use_imm_i && imm_i >= 8'd64 && a_i[DW-1])
        |=> (result_o == '1));
    // R9
    unpack_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_i == 3'd5 && lane_i != 2'd3)
        |=> (result_o[7:0] == $past(a_i[7:0])));
    // R10
    byte_shift_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_i <= 3'd2 && lane_i == 2'd0) |=> (result_o == '0));
endmodule

// File: tb/sim_psp_unit.sv
module sim_psp_unit;
    localparam real TCK = 8.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op_i = '0;
    logic [1:0]  lane_i = '0;
    logic        use_imm_i = 1'b0;
    logic [7:0]  imm_i = '0;
    logic [63:0] a_i = '0;
    logic [63:0] b_i = '0;
    logic        out_valid_o;
    logic [63:0] result_o;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        logic [63:0] exp;
        string       req;
    } item_t;
    item_t sb[$];

    always #(TCK/2) clk = ~clk;

    psp_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_i(op_i), .lane_i(lane_i),
        .use_imm_i(use_imm_i), .imm_i(imm_i), .a_i(a_i), .b_i(b_i),
        .out_valid_o(out_valid_o), .result_o(result_o)
    );

    function automatic logic [63:0] msk(input int w);
        return (w >= 64) ? '1 : ((64'd1 << w) - 64'd1);
    endfunction

    function automatic logic [63:0] model(input logic [2:0] op, input logic [1:0] ln,
                                          input logic ui, input logic [7:0] imm,
                                          input logic [63:0] a, input logic [63:0] b);
        logic [63:0] r = '0;
        logic [63:0] c = ui ? {56'd0, imm} : b;
        int w;
        if (op <= 3'd2) begin
            if (ln == 2'd0) return '0;
            w = 8 << ln;
            for (int k = 0; k < 64 / w; k++) begin
                logic [63:0] v = (a >> (k * w)) & msk(w);
                logic [63:0] e;
                int n;
                if (op == 3'd0)      e = (c >= 64'(w)) ? '0 : ((v << c) & msk(w));
                else if (op == 3'd1) e = (c >= 64'(w)) ? '0 : (v >> c);
                else begin
                    n = (c >= 64'(w)) ? w - 1 : int'(c);
                    e = v >> n;
                    if (v[w-1]) e = e | (msk(w) & ~(msk(w) >> n));
                end
                r = r | (e << (k * w));
            end
            return r;
        end
        if (op == 3'd3 || op == 3'd4) begin
            if (op == 3'd4 && ln != 2'd1) return '0;
            if (ln != 2'd1 && ln != 2'd2) return '0;
            w = (ln == 2'd1) ? 16 : 32;
            for (int k = 0; k < 128 / w; k++) begin
                logic [63:0] src = (k < 64 / w) ? a : b;
                int idx = k % (64 / w);
                longint s;
                longint lo, hi;
                if (w == 16) s = longint'($signed(src[idx*16 +: 16]));
                else         s = longint'($signed(src[idx*32 +: 32]));
                if (op == 3'd4) begin lo = 0; hi = 255; end
                else begin lo = -(longint'(1) << (w/2 - 1)); hi = (longint'(1) << (w/2 - 1)) - 1; end
                if (s < lo) s = lo;
                if (s > hi) s = hi;
                r = r | ((64'(s) & msk(w/2)) << (k * (w/2)));
            end
            return r;
        end
        if (op == 3'd5 || op == 3'd6) begin
            if (ln == 2'd3) return '0;
            w = 8 << ln;
            for (int k = 0; k < 64 / w; k++) begin
                logic [63:0] src = (k % 2 == 1) ? b : a;
                int idx = k / 2 + ((op == 3'd6) ? 32 / w : 0);
                r = r | (((src >> (idx * w)) & msk(w)) << (k * w));
            end
            return r;
        end
        return '0;
    endfunction

    task automatic send(input logic [2:0] op, input logic [1:0] ln, input logic ui,
                        input logic [7:0] imm, input logic [63:0] a, input logic [63:0] b,
                        input string req);
        item_t it;
        @(negedge clk);
        in_valid  = 1'b1;
        op_i      = op;
        lane_i    = ln;
        use_imm_i = ui;
        imm_i     = imm;
        a_i       = a;
        b_i       = b;
        it.exp    = model(op, ln, ui, imm, a, b);
        it.req    = req;
        sb.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            a_i      = 64'hdead_beef_0bad_f00d;
        end
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && out_valid_o) begin
                item_t it;
                n_cmp++;
                if (sb.size() == 0) begin
                    n_bad++;
                    $display("FAIL R1: unexpected result act=%h exp=none", result_o);
                end else begin
                    it = sb.pop_front();
                    if (result_o !== it.exp) begin
                        n_bad++;
                        $display("FAIL %s: act=%h exp=%h", it.req, result_o, it.exp);
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        #(TCK * 100000);
        n_bad++;
        $display("FAIL R1: watchdog expired act=hung exp=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] x = 64'h8123_4567_f0e1_d2c3;
        #(TCK * 3);
        // R1 reset state
        n_cmp++;
        if (out_valid_o !== 1'b0 || result_o !== '0) begin
            n_bad++;
            $display("FAIL R1: reset act=%b/%h exp=0/0", out_valid_o, result_o);
        end
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        // R2 left shifts, immediate count
        send(3'd0, 2'd1, 1, 8'd4,  x, '0, "R2");
        send(3'd0, 2'd2, 1, 8'd9,  x, '0, "R2");
        send(3'd0, 2'd3, 1, 8'd24, x, '0, "R2");
        // R3 logical right
        send(3'd1, 2'd1, 1, 8'd3,  x, '0, "R3");
        send(3'd1, 2'd2, 1, 8'd31, x, '0, "R3");
        send(3'd1, 2'd3, 1, 8'd8,  x, '0, "R3");
        // R4 arithmetic right
        send(3'd2, 2'd1, 1, 8'd5,  x, '0, "R4");
        send(3'd2, 2'd2, 1, 8'd17, x, '0, "R4");
        send(3'd2, 2'd3, 1, 8'd40, x, '0, "R4");
        idle(1);
        // R5 count from b, high bits matter
        send(3'd0, 2'd1, 0, 8'd0, x, 64'd2, "R5");
        send(3'd1, 2'd2, 0, 8'd1, x, 64'h0000_0001_0000_0003, "R5");
        send(3'd2, 2'd1, 0, 8'd1, x, 64'h8000_0000_0000_0001, "R5");
        // R6 boundary counts
        send(3'd0, 2'd1, 1, 8'd15, x, '0, "R6");
        send(3'd0, 2'd1, 1, 8'd16, x, '0, "R6");
        send(3'd1, 2'd2, 0, 8'd0,  x, 64'd32, "R6");
        send(3'd2, 2'd2, 0, 8'd0,  x, 64'd32, "R6");
        send(3'd2, 2'd3, 1, 8'd64, x, '0, "R6");
        send(3'd1, 2'd3, 1, 8'd255, x, '0, "R6");
        send(3'd2, 2'd3, 1, 8'd63, x, '0, "R6");
        // R7 signed pack boundaries
        send(3'd3, 2'd1, 0, 0, 64'h007f_0080_ff80_ff7f, 64'h8000_7fff_0000_ffff, "R7");
        send(3'd3, 2'd2, 0, 0, 64'h0000_7fff_0000_8000, 64'hffff_8000_ffff_7fff, "R7");
        // R8 unsigned pack
        send(3'd4, 2'd1, 0, 0, 64'h00ff_0100_ffff_0080, 64'h8000_7fff_0000_0001, "R8");
        // R9 unpack every size, both halves
        for (int ln = 0; ln < 3; ln++) begin
            send(3'd5, 2'(ln), 0, 0, 64'h0706_0504_0302_0100, 64'h1716_1514_1312_1110, "R9");
            send(3'd6, 2'(ln), 0, 0, 64'h0706_0504_0302_0100, 64'h1716_1514_1312_1110, "R9");
        end
        // R10 unsupported combinations
        send(3'd0, 2'd0, 1, 8'd1, x, x, "R10");
        send(3'd2, 2'd0, 1, 8'd1, x, x, "R10");
        send(3'd3, 2'd0, 0, 0, x, x, "R10");
        send(3'd3, 2'd3, 0, 0, x, x, "R10");
        send(3'd4, 2'd2, 0, 0, x, x, "R10");
        send(3'd5, 2'd3, 0, 0, x, x, "R10");
        send(3'd7, 2'd1, 0, 0, x, x, "R10");
        idle(3);
        // random back-to-back traffic
        for (int i = 0; i < 400; i++) begin
            logic [2:0] op = 3'($urandom_range(0, 7));
            logic [1:0] ln = 2'($urandom_range(0, 3));
            logic ui = 1'($urandom_range(0, 1));
            logic [7:0] im = 8'($urandom_range(0, 80));
            logic [63:0] ra = {$urandom, $urandom};
            logic [63:0] rb = (i % 3 == 0) ? 64'($urandom_range(0, 70)) : {$urandom, $urandom};
            string rq;
            if (op <= 3'd2 && ln == 2'd0) rq = "R10";
            else if (op <= 3'd2)          rq = "R5";
            else if (op == 3'd3)          rq = "R7";
            else if (op == 3'd4)          rq = "R8";
            else if (op == 3'd7)          rq = "R10";
            else                          rq = "R9";
            send(op, ln, ui, im, ra, rb, rq);
            if (i % 37 == 0) idle(1);
        end
        idle(4);
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL R1: results missing act=%0d exp=0", sb.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule